// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block is a purely combinational 32-bit operand shifter meant to sit directly in front of an ALU input. It takes one data word, a 3-bit shift kind, an 8-bit shift distance and the current carry flag. In the same cycle it returns the shifted word and the carry the shift produces. Immediate distances (0 to 31) and distances read from a register (0 to 255) use the same input, and every distance bit is honoured.

Every shift kind defines its carry-out. For left shifts it is the last bit pushed out of the top. For right shifts and rotates it is the last bit pushed out of the bottom. The extend-rotate kind moves the incoming carry into the top bit. Distances of zero, exactly the word width, and beyond the word width each have their own defined result. Instruction decode, the ALU and flag write-back are outside this block.

Top module: `barsh_top`

## Requirements
- R1: Kind code 0 (logical left) with distance n in 1..31 gives `opnd_i << n`, zero-filled, with carry-out equal to `opnd_i[32-n]`.
- R2: Kind code 1 (arithmetic left) gives the same result and carry as kind code 0 for every value, distance and carry-in.
- R3: Kind code 2 (logical right) with n in 1..31 gives `opnd_i >> n`, zero-filled from the top, with carry-out equal to `opnd_i[n-1]`.
- R4: Kind code 3 (arithmetic right) with n in 1..31 copies bit 31 into the vacated upper bits, with carry-out equal to `opnd_i[n-1]`.
- R5: Kind code 4 (rotate right) with nonzero n rotates by n mod 32, so bits leaving bit 0 enter bit 31. Carry-out equals bit 31 of the result. A nonzero multiple of 32 leaves the word unchanged with carry equal to `opnd_i[31]`.
- R6: Kind code 5 (extend rotate) ignores the distance. The result is `{carry_i, opnd_i[31:1]}` and carry-out is `opnd_i[0]`.
- R7: A distance of 0 with any kind except code 5 passes the word through unchanged, with carry-out equal to `carry_i`.
- R8: Kind codes 0/1 at distance exactly 32 give result 0 with carry `opnd_i[0]`. Kind code 2 at distance 32 gives result 0 with carry `opnd_i[31]`.
- R9: Kind codes 0, 1 and 2 at distances 33..255 give result 0 and carry-out 0.
- R10: Kind code 3 at distances 32..255 gives a result with every bit equal to `opnd_i[31]` and carry-out `opnd_i[31]`.
- R11: Kind codes 6 and 7 are reserved. They pass the word through unchanged, with carry-out equal to `carry_i`, at any distance.
- R12: All 8 distance bits take part. For example, rotate by 33 equals rotate by 1, and a distance of 255 falls in the beyond-width class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Data word to be shifted |
| kind_i | input | 3 | Shift kind: 0 lsl, 1 asl, 2 lsr, 3 asr, 4 ror, 5 extend-rotate, 6/7 reserved |
| amt_i | input | 8 | Shift distance, 0..255 |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry produced by the shift |

## Verification
The hardest cases to reach are the carry at the width boundary and beyond it: distance exactly 32, rotates by nonzero multiples of 32, and distances whose low five bits are zero while higher bits are set. Random distances almost never land on these values. Directed tasks drive the distances 0, 1, 31, 32, 33, 64, 96, 200 and 255 on purpose. They use words with distinct top and bottom bits, so that a carry taken from the wrong end shows up. A random sweep over all kinds and the full distance range follows the directed tasks.

// File: rtl/barsh_pkg.sv
// barsh_pkg: shared kind codes and the distance-class record for the shifter.
// Assumes the kind field is 3 bits wide; codes 6 and 7 are left reserved.
package barsh_pkg;

    localparam logic [2:0] SH_LSL = 3'd0;
    localparam logic [2:0] SH_ASL = 3'd1;
    localparam logic [2:0] SH_LSR = 3'd2;
    localparam logic [2:0] SH_ASR = 3'd3;
    localparam logic [2:0] SH_ROR = 3'd4;
    localparam logic [2:0] SH_RRX = 3'd5;

    // Distance classification relative to the data width.
    typedef struct packed {
        logic is_zero;   // distance is 0
        logic below_w;   // distance < width (includes 0)
        logic equal_w;   // distance == width
        logic above_w;   // distance > width
    } amt_class_t;

endpackage

// File: rtl/barsh_amt_decode.sv
// barsh_amt_decode: sorts the shift distance into zero / in-range / equal
// to width / beyond width, and extracts the low bits used as a stage select.
// Assumes DATA_W is a power of two and AMT_W is wide enough to hold DATA_W.
module barsh_amt_decode
    import barsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0] amt_i,
    output amt_class_t       cls_o,
    output logic [SH_W-1:0]  low_o
);

    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(DATA_W);

    // Classify the full distance against the word width.
    always_comb begin
        cls_o.is_zero = (amt_i == '0);
        cls_o.below_w = (amt_i < W_AMT);
        cls_o.equal_w = (amt_i == W_AMT);
        cls_o.above_w = (amt_i > W_AMT);
        low_o         = amt_i[SH_W-1:0];
    end

    // Exactly one class applies to any distance.
    always_comb begin
        AST_CLASS_ONEHOT: assert ($onehot({cls_o.is_zero, cls_o.below_w & ~cls_o.is_zero,
                                           cls_o.equal_w, cls_o.above_w}))
            else $error("distance class not unique"); // R12
    end

endmodule

// File: rtl/barsh_net.sv
// barsh_net: logarithmic shift network, one stage per distance bit.
// MODE 0 shifts left with zero fill, 1 shifts right with zero fill,
// 2 shifts right copying the top bit, 3 rotates right.
// Assumes dist_i < DATA_W; out-of-range distances are handled by the caller.
module barsh_net #(
    parameter int DATA_W = 32,
    parameter int MODE   = 0,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din_i,
    input  logic [SH_W-1:0]   dist_i,
    output logic [DATA_W-1:0] dout_o
);

    logic [SH_W:0][DATA_W-1:0] stg;
    logic                      sign_b;

    assign sign_b = din_i[DATA_W-1];
    assign stg[0] = din_i;

    genvar k;
    generate
        for (k = 0; k < SH_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            if (MODE == 0) begin : g_left
                // Stage k: move left by 2^k when its distance bit is set.
                assign stg[k+1] = dist_i[k] ? {stg[k][DATA_W-1-STEP:0], {STEP{1'b0}}} : stg[k];
            end else if (MODE == 1) begin : g_rlog
                // Stage k: move right by 2^k, zeros entering the top.
                assign stg[k+1] = dist_i[k] ? {{STEP{1'b0}}, stg[k][DATA_W-1:STEP]} : stg[k];
            end else if (MODE == 2) begin : g_rari
                // Stage k: move right by 2^k, the original sign entering the top.
                assign stg[k+1] = dist_i[k] ? {{STEP{sign_b}}, stg[k][DATA_W-1:STEP]} : stg[k];
            end else begin : g_rot
                // Stage k: rotate right by 2^k.
                assign stg[k+1] = dist_i[k] ? {stg[k][STEP-1:0], stg[k][DATA_W-1:STEP]} : stg[k];
            end
        end
    endgenerate

    assign dout_o = stg[SH_W];

    // A rotate never changes the number of set bits.
    if (MODE == 3) begin : g_rot_chk
        always_comb begin
            AST_NET_ROT_KEEP: assert ($countones(dout_o) == $countones(din_i))
                else $error("rotate network lost bits"); // R5
        end
    end

endmodule

// File: rtl/barsh_carry.sv
// barsh_carry: picks the shifter carry-out for each kind and distance class.
// Assumes the rotate result for the same operand is supplied as rot_msb_i.
module barsh_carry
    import barsh_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [2:0]        kind_i,
    input  amt_class_t        cls_i,
    input  logic [SH_W-1:0]   low_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              carry_i,
    input  logic              rot_msb_i,
    output logic              carry_o
);

    logic [SH_W-1:0] up_idx;
    logic [SH_W-1:0] dn_idx;

    // Bit positions of the last bit leaving the top and the bottom.
    always_comb begin
        up_idx = SH_W'(DATA_W - int'(low_i));
        dn_idx = low_i - SH_W'(1);
    end

    // Carry selection per kind; zero distance keeps the incoming carry.
    always_comb begin
        case (kind_i)
            SH_LSL, SH_ASL: begin
                if (cls_i.is_zero)      carry_o = carry_i;
                else if (cls_i.below_w) carry_o = din_i[up_idx];
                else if (cls_i.equal_w) carry_o = din_i[0];
                else                    carry_o = 1'b0;
            end
            SH_LSR: begin
                if (cls_i.is_zero)      carry_o = carry_i;
                else if (cls_i.below_w) carry_o = din_i[dn_idx];
                else if (cls_i.equal_w) carry_o = din_i[DATA_W-1];
                else                    carry_o = 1'b0;
            end
            SH_ASR: begin
                if (cls_i.is_zero)      carry_o = carry_i;
                else if (cls_i.below_w) carry_o = din_i[dn_idx];
                else                    carry_o = din_i[DATA_W-1];
            end
            SH_ROR:  carry_o = cls_i.is_zero ? carry_i : rot_msb_i;
            SH_RRX:  carry_o = din_i[0];
            default: carry_o = carry_i;
        endcase
    end

endmodule

// File: rtl/barsh_top.sv
// barsh_top: combinational operand shifter with carry-out in front of an ALU.
// Sorts the distance, runs four shift networks in parallel, then selects the
// result by kind and distance class. Assumes DATA_W is a power of two.
module barsh_top
    import barsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [2:0]        kind_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);

    localparam int SH_W = $clog2(DATA_W);
    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(DATA_W);

    amt_class_t        cls;
    logic [SH_W-1:0]   low;
    logic [DATA_W-1:0] lsl_q;
    logic [DATA_W-1:0] lsr_q;
    logic [DATA_W-1:0] asr_q;
    logic [DATA_W-1:0] ror_q;

    barsh_amt_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
        .amt_i (amt_i),
        .cls_o (cls),
        .low_o (low)
    );

    barsh_net #(.DATA_W(DATA_W), .MODE(0)) u_lsl (.din_i(opnd_i), .dist_i(low), .dout_o(lsl_q));
    barsh_net #(.DATA_W(DATA_W), .MODE(1)) u_lsr (.din_i(opnd_i), .dist_i(low), .dout_o(lsr_q));
    barsh_net #(.DATA_W(DATA_W), .MODE(2)) u_asr (.din_i(opnd_i), .dist_i(low), .dout_o(asr_q));
    barsh_net #(.DATA_W(DATA_W), .MODE(3)) u_ror (.din_i(opnd_i), .dist_i(low), .dout_o(ror_q));

    barsh_carry #(.DATA_W(DATA_W)) u_cy (
        .kind_i    (kind_i),
        .cls_i     (cls),
        .low_i     (low),
        .din_i     (opnd_i),
        .carry_i   (carry_i),
        .rot_msb_i (ror_q[DATA_W-1]),
        .carry_o   (carry_o)
    );

    // Result selection per kind and distance class.
    always_comb begin
        case (kind_i)
            SH_LSL, SH_ASL: result_o = cls.is_zero ? opnd_i : (cls.below_w ? lsl_q : '0);
            SH_LSR:         result_o = cls.is_zero ? opnd_i : (cls.below_w ? lsr_q : '0);
            SH_ASR:         result_o = cls.is_zero ? opnd_i :
                                       (cls.below_w ? asr_q : {DATA_W{opnd_i[DATA_W-1]}});
            SH_ROR:         result_o = ror_q;
            SH_RRX:         result_o = {carry_i, opnd_i[DATA_W-1:1]};
            default:        result_o = opnd_i;
        endcase
    end

    // Port-level relations between operand, kind, distance and outputs.
    always_comb begin
        if (amt_i == '0 && kind_i != SH_RRX) begin
            AST_ZERO_PASS: assert (result_o == opnd_i && carry_o == carry_i)
                else $error("zero distance altered data"); // R7
        end
        if (kind_i == SH_RRX) begin
            AST_RRX_EXT: assert (result_o[DATA_W-1] == carry_i && carry_o == opnd_i[0])
                else $error("extend rotate wrong"); // R6
        end
        if (kind_i == SH_ROR && amt_i != '0) begin
            AST_ROR_CARRY: assert (carry_o == result_o[DATA_W-1] &&
                                   $countones(result_o) == $countones(opnd_i))
                else $error("rotate carry wrong"); // R5
        end
        if ((kind_i == SH_LSL || kind_i == SH_ASL || kind_i == SH_LSR) && amt_i > W_AMT) begin
            AST_FLUSH_ZERO: assert (result_o == '0 && !carry_o)
                else $error("beyond-width shift not flushed"); // R9
        end
        if (kind_i == SH_ASR && amt_i >= W_AMT) begin
            AST_ASR_SAT: assert (($countones(result_o) == 0 || $countones(result_o) == DATA_W) &&
                                 carry_o == result_o[0] && carry_o == opnd_i[DATA_W-1])
                else $error("arithmetic saturation wrong"); // R10
        end
    end

endmodule

// File: tb/barsh_top_tb.sv
module barsh_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd;
    logic [2:0]  kind;
    logic [7:0]  amt;
    logic        cin;
    logic [31:0] res;
    logic        cout;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    barsh_top u_dut (
        .opnd_i   (opnd),
        .kind_i   (kind),
        .amt_i    (amt),
        .carry_i  (cin),
        .result_o (res),
        .carry_o  (cout)
    );

    // Reference model built from the requirements with wide arithmetic.
    function automatic logic [32:0] ref_fn(input logic [31:0] v, input logic [2:0] k,
                                           input logic [7:0] n, input logic c);
        logic [63:0] t;
        logic [31:0] r;
        int          m;
        if (k == 3'd5) return {v[0], c, v[31:1]};
        if (k >= 3'd6 || n == 0) return {c, v};
        case (k)
            3'd0, 3'd1: begin
                if (n > 32) return 33'd0;
                t = {32'd0, v} << n;
                return {t[32], t[31:0]};
            end
            3'd2: begin
                if (n > 32) return 33'd0;
                t = {v, 32'd0} >> n;
                return {t[31], t[63:32]};
            end
            3'd3: begin
                if (n >= 32) return {v[31], {32{v[31]}}};
                t = $signed({v, 32'd0}) >>> n;
                return {t[31], t[63:32]};
            end
            default: begin
                m = int'(n) % 32;
                t = {v, v} >> m;
                r = t[31:0];
                return {r[31], r};
            end
        endcase
    endfunction

    task automatic apply(input logic [31:0] v, input logic [2:0] k, input logic [7:0] n,
                         input logic c, input string tag);
        logic [32:0] exp;
        @(negedge clk);
        opnd = v; kind = k; amt = n; cin = c;
        #1;
        exp = ref_fn(v, k, n, c);
        checks++;
        if ({cout, res} !== exp) begin
            errors++;
            $display("FAIL %s kind=%0d amt=%0d v=%h cin=%b: got res=%h c=%b exp res=%h c=%b",
                     tag, k, n, v, c, res, cout, exp[31:0], exp[32]);
        end
    endtask

    task automatic t_zero;   // R7
        for (int k = 0; k < 5; k++) begin
            apply(32'hA5C3_0F81, 3'(k), 8'd0, 1'b1, "R7");
            apply(32'h0000_0001, 3'(k), 8'd0, 1'b0, "R7");
        end
    endtask

    task automatic t_lsl;    // R1
        apply(32'h8000_0001, 3'd0, 8'd1,  1'b0, "R1");
        apply(32'h1234_5678, 3'd0, 8'd5,  1'b1, "R1");
        apply(32'h0000_0003, 3'd0, 8'd31, 1'b0, "R1");
        apply(32'h0000_0002, 3'd0, 8'd31, 1'b0, "R1");
    endtask

    task automatic t_asl;    // R2
        apply(32'h8000_0001, 3'd1, 8'd1,  1'b0, "R2");
        apply(32'hF00D_BEEF, 3'd1, 8'd13, 1'b1, "R2");
        apply(32'h0000_0001, 3'd1, 8'd32, 1'b0, "R2");
        apply(32'hFFFF_FFFF, 3'd1, 8'd40, 1'b1, "R2");
    endtask

    task automatic t_lsr;    // R3
        apply(32'h8000_0001, 3'd2, 8'd1,  1'b0, "R3");
        apply(32'hDEAD_BEEF, 3'd2, 8'd8,  1'b0, "R3");
        apply(32'h4000_0000, 3'd2, 8'd31, 1'b1, "R3");
    endtask

    task automatic t_asr;    // R4
        apply(32'h8000_0001, 3'd3, 8'd1,  1'b0, "R4");
        apply(32'h8F00_0000, 3'd3, 8'd12, 1'b0, "R4");
        apply(32'h7F00_00F0, 3'd3, 8'd5,  1'b1, "R4");
        apply(32'hC000_0000, 3'd3, 8'd31, 1'b0, "R4");
    endtask

    task automatic t_ror;    // R5
        apply(32'h0000_0001, 3'd4, 8'd1,  1'b0, "R5");
        apply(32'h1234_5678, 3'd4, 8'd16, 1'b0, "R5");
        apply(32'h8000_0002, 3'd4, 8'd31, 1'b0, "R5");
        apply(32'h8000_0000, 3'd4, 8'd32, 1'b0, "R5");
        apply(32'h7FFF_FFFF, 3'd4, 8'd64, 1'b1, "R5");
        apply(32'hC0DE_0001, 3'd4, 8'd96, 1'b0, "R5");
    endtask

    task automatic t_rrx;    // R6
        apply(32'h0000_0001, 3'd5, 8'd0,   1'b1, "R6");
        apply(32'hFFFF_FFFE, 3'd5, 8'd7,   1'b0, "R6");
        apply(32'h1357_9BDF, 3'd5, 8'd200, 1'b1, "R6");
    endtask

    task automatic t_eq32;   // R8
        apply(32'h0000_0001, 3'd0, 8'd32, 1'b0, "R8");
        apply(32'hFFFF_FFFE, 3'd0, 8'd32, 1'b1, "R8");
        apply(32'h8000_0000, 3'd2, 8'd32, 1'b0, "R8");
        apply(32'h7FFF_FFFF, 3'd2, 8'd32, 1'b1, "R8");
    endtask

    task automatic t_beyond; // R9
        apply(32'hFFFF_FFFF, 3'd0, 8'd33,  1'b1, "R9");
        apply(32'hFFFF_FFFF, 3'd2, 8'd33,  1'b1, "R9");
        apply(32'hFFFF_FFFF, 3'd1, 8'd100, 1'b1, "R9");
        apply(32'hFFFF_FFFF, 3'd2, 8'd255, 1'b1, "R9");
    endtask

    task automatic t_asr_big; // R10
        apply(32'h8000_0000, 3'd3, 8'd32,  1'b0, "R10");
        apply(32'h7FFF_FFFF, 3'd3, 8'd33,  1'b1, "R10");
        apply(32'h8123_4567, 3'd3, 8'd255, 1'b0, "R10");
    endtask

    task automatic t_reserved; // R11
        apply(32'hCAFE_F00D, 3'd6, 8'd4,   1'b1, "R11");
        apply(32'hCAFE_F00D, 3'd7, 8'd200, 1'b0, "R11");
        apply(32'h0000_0001, 3'd7, 8'd1,   1'b1, "R11");
    endtask

    task automatic t_wide;   // R12
        apply(32'h0000_0003, 3'd4, 8'd33,  1'b0, "R12");
        apply(32'h0000_0001, 3'd0, 8'd255, 1'b1, "R12");
        apply(32'h8000_0000, 3'd2, 8'd160, 1'b1, "R12");
        for (int i = 0; i < 400; i++)
            apply($urandom, 3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)),
                  1'($urandom), "R12");
    endtask

    initial begin
        opnd = '0; kind = '0; amt = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        apply(32'h0, 3'd0, 8'd0, 1'b0, "R7");
        t_zero;
        t_lsl;
        t_asl;
        t_lsr;
        t_asr;
        t_ror;
        t_rrx;
        t_eq32;
        t_beyond;
        t_asr_big;
        t_reserved;
        t_wide;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule